// File: doc/BRIEF.md
# PWM Fault Input Acceptance Logic

This block takes one external control input of a PWM channel, such as a fault or current-limit comparator, and decides each clock cycle whether that input counts as active. A programmable acceptance mode makes the input count while it is high, on a rising edge, or on any edge. Three further modes capture the event in a set/reset latch. The latch holds until a termination qualifier clears it. The qualifier comes from one of several PWM status signals, and it can be inverted.

A software control bit can be inserted at one of three places: into the input path, as a gate on acceptance, or as a gate on the termination qualifier. A bypass path replaces the local result with the result of a neighbouring generator. The block passes its own local result out on a separate port, so that neighbours can use it in the same way. The input goes through one synchroniser stage, and both results are registered.

Top module: `pwm_fault_accept`

## Requirements
- R1: While `rst` is high at a rising clock edge, every internal register and both outputs `local_acc` and `accepted` are cleared to 0 at that edge.
- R2: `fault_in` passes through one register stage. A change applied before clock edge k first appears on `local_acc` and `accepted` after edge k+1, and not after edge k.
- R3: With `cfg_mode` = 000 (level), `local_acc` follows the effective input with the latency of R2.
- R4: With `cfg_mode` = 001 (rising) or 010 (any edge), `local_acc` is high for one cycle when the effective input differs from its value one cycle earlier. In mode 001 it must have gone from 0 to 1. In mode 010 either direction counts.
- R5: The latched modes are `cfg_mode` = 011, 100 and 101. They set the result on a high level, a rising edge or any edge of the effective input. The result then stays high until the termination signal is high at a clock edge with no set.
- R6: When set and termination occur at the same edge in a latched mode, the result becomes 1 if `cfg_rst_dom` = 0 and 0 if `cfg_rst_dom` = 1.
- R7: `cfg_term_sel` selects the termination qualifier before inversion: 000 and 111 give constant 1, 001 `duty_act`, 010 `blank_act`, 011 `gen_trig`, 100 `pci_src1`, 101 `pci_src8`, 110 `pci_src9`.
- R8: `cfg_term_inv` = 1 inverts the selected qualifier. With 0 it passes unchanged.
- R9: `cfg_sw_route` places `cfg_sw_bit` as follows. With 00 or 11 it is ORed into the synchronised input. With 01 it ANDs with the input (acceptance gate). With 10 it ANDs with the qualifier before inversion. Outside its selected route the bit has no effect.
- R10: With `cfg_byp_en` = 1, `accepted` takes `nbr_acc[i]` one edge later. `cfg_byp_sel` gives i: 000→0, 001→1, 010→2, 011→3, 101→5, 111→7, and the reserved codes 100 and 110 give 0.
- R11: The reserved mode codes 110 and 111 behave exactly as level mode 000.
- R12: `local_acc` always carries the local acceptance result, whatever the value of `cfg_byp_en`. With bypass off, `accepted` equals `local_acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_in | input | 1 | Raw external control input |
| duty_act | input | 1 | Duty-cycle-active status |
| blank_act | input | 1 | Leading-edge-blanking-active status |
| gen_trig | input | 1 | Generator-triggered status |
| pci_src1 | input | 1 | Qualifier source 1 |
| pci_src8 | input | 1 | Qualifier source 8 |
| pci_src9 | input | 1 | Qualifier source 9 |
| nbr_acc | input | NGEN | Local results of neighbouring generators |
| cfg_mode | input | 3 | Acceptance mode |
| cfg_rst_dom | input | 1 | Latch dominance: 0 set wins, 1 reset wins |
| cfg_term_sel | input | 3 | Termination qualifier source select |
| cfg_term_inv | input | 1 | Termination qualifier inversion |
| cfg_sw_bit | input | 1 | Software control bit |
| cfg_sw_route | input | 2 | Software bit insertion point |
| cfg_byp_en | input | 1 | Bypass enable |
| cfg_byp_sel | input | 3 | Bypass source select |
| local_acc | output | 1 | Registered local acceptance result |
| accepted | output | 1 | Registered accepted-active output |

## Verification
In the latched modes, a set from the input and a termination from the qualifier can arrive at the same clock edge. The latch dominance bit alone decides the outcome. The bench brings this about by driving the input and every qualifier source with independent random values over every mode, qualifier select, polarity, dominance and software route. Many cycles therefore carry set and termination together. Each cycle's result is judged against a cycle model written from the requirements, which resolves the collision as set-wins or reset-wins according to the dominance bit.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

  typedef enum logic [2:0] {
    ACC_LEVEL    = 3'd0,
    ACC_RISE     = 3'd1,
    ACC_ANY      = 3'd2,
    ACC_LAT      = 3'd3,
    ACC_LAT_RISE = 3'd4,
    ACC_LAT_ANY  = 3'd5
  } acc_mode_e;

  typedef enum logic [1:0] {
    SW_INPUT = 2'd0,
    SW_ACCQ  = 2'd1,
    SW_TERMQ = 2'd2
  } sw_route_e;

  // reserved codes fold onto code 0
  function automatic acc_mode_e norm_mode(input logic [2:0] code);
    return (code > 3'd5) ? ACC_LEVEL : acc_mode_e'(code);
  endfunction

  function automatic sw_route_e norm_route(input logic [1:0] code);
    return (code == 2'd3) ? SW_INPUT : sw_route_e'(code);
  endfunction

endpackage

// File: rtl/pfa_term_qual.sv
module pfa_term_qual #(
  parameter int SEL_W = 3,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  input  logic             sw_gate_en,
  input  logic             sw_bit,
  output logic             term
);

  logic q_raw;
  logic q_gated;

  always_comb begin
    q_raw = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) q_raw = src_vec[i];
    end
  end

  assign q_gated = sw_gate_en ? (q_raw & sw_bit) : q_raw;
  assign term    = q_gated ^ inv;

  // R7
  const_qual_chk: assert property (@(posedge clk) disable iff (rst)
    ((sel == '0) || (sel == '1)) && !sw_gate_en |-> term == !inv);

  // R9
  sw_term_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sw_gate_en && !sw_bit |-> term == inv);

endmodule

// File: rtl/pfa_accept_core.sv
module pfa_accept_core
  import pfa_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_eff,
  input  acc_mode_e mode,
  input  logic      rst_dom,
  input  logic      term,
  output logic      r_next,
  output logic      r_q
);

  logic e_q;
  logic rise_c, any_c, set_c, latched;

  always_ff @(posedge clk) begin
    if (rst) e_q <= 1'b0;
    else     e_q <= in_eff;
  end

  assign rise_c = in_eff & ~e_q;
  assign any_c  = in_eff ^ e_q;

  always_comb begin
    unique case (mode)
      ACC_RISE, ACC_LAT_RISE: set_c = rise_c;
      ACC_ANY,  ACC_LAT_ANY:  set_c = any_c;
      default:                set_c = in_eff;
    endcase
  end

  assign latched = (mode == ACC_LAT) || (mode == ACC_LAT_RISE) || (mode == ACC_LAT_ANY);

  always_comb begin
    if (!latched)     r_next = set_c;
    else if (rst_dom) r_next = term ? 1'b0 : (set_c ? 1'b1 : r_q);
    else              r_next = set_c ? 1'b1 : (term ? 1'b0 : r_q);
  end

  always_ff @(posedge clk) begin
    if (rst) r_q <= 1'b0;
    else     r_q <= r_next;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    latched && !rst_dom && set_c |=> r_q);

  // R6
  reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
    latched && rst_dom && term |=> !r_q);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    latched && !term && r_q |=> r_q);

  // R4
  edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == ACC_RISE) && !in_eff |=> !r_q);

endmodule

// File: rtl/pfa_bypass_mux.sv
module pfa_bypass_mux #(
  parameter int NGEN  = 8,
  parameter int SEL_W = 3,
  localparam int IDX_W = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic [NGEN-1:0]  nbr_acc,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  input  logic             local_next,
  output logic [IDX_W-1:0] idx,
  output logic             out_next
);

  int idx_i;

  always_comb begin
    case (sel)
      SEL_W'(1): idx_i = 1;
      SEL_W'(2): idx_i = 2;
      SEL_W'(3): idx_i = 3;
      SEL_W'(5): idx_i = 5;
      SEL_W'(7): idx_i = 7;
      default:   idx_i = 0;
    endcase
    if (idx_i >= NGEN) idx_i = 0;
    idx = IDX_W'(idx_i);
  end

  assign out_next = en ? nbr_acc[idx] : local_next;

endmodule

// File: rtl/pwm_fault_accept.sv
module pwm_fault_accept
  import pfa_pkg::*;
#(
  parameter int NGEN  = 8,
  parameter int SEL_W = 3,
  localparam int IDX_W = (NGEN > 1) ? $clog2(NGEN) : 1,
  localparam int NSRC  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_in,
  input  logic             duty_act,
  input  logic             blank_act,
  input  logic             gen_trig,
  input  logic             pci_src1,
  input  logic             pci_src8,
  input  logic             pci_src9,
  input  logic [NGEN-1:0]  nbr_acc,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_rst_dom,
  input  logic [SEL_W-1:0] cfg_term_sel,
  input  logic             cfg_term_inv,
  input  logic             cfg_sw_bit,
  input  logic [1:0]       cfg_sw_route,
  input  logic             cfg_byp_en,
  input  logic [SEL_W-1:0] cfg_byp_sel,
  output logic             local_acc,
  output logic             accepted
);

  logic            in_sync;
  logic            in_eff;
  sw_route_e       route;
  acc_mode_e       mode;
  logic [NSRC-1:0] src_vec;
  logic            term;
  logic            r_next;
  logic            out_next;
  logic [IDX_W-1:0] byp_idx;

  always_ff @(posedge clk) begin
    if (rst) in_sync <= 1'b0;
    else     in_sync <= fault_in;
  end

  assign route  = norm_route(cfg_sw_route);
  assign mode   = norm_mode(cfg_mode);
  assign in_eff = (in_sync | ((route == SW_INPUT) & cfg_sw_bit))
                & ((route != SW_ACCQ) | cfg_sw_bit);

  // source order follows the select code; entries past 6 are the constant
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      if      (g == 1) begin : g_d  assign src_vec[g] = duty_act;  end
      else if (g == 2) begin : g_b  assign src_vec[g] = blank_act; end
      else if (g == 3) begin : g_t  assign src_vec[g] = gen_trig;  end
      else if (g == 4) begin : g_s1 assign src_vec[g] = pci_src1;  end
      else if (g == 5) begin : g_s8 assign src_vec[g] = pci_src8;  end
      else if (g == 6) begin : g_s9 assign src_vec[g] = pci_src9;  end
      else             begin : g_k  assign src_vec[g] = 1'b1;      end
    end
  endgenerate

  pfa_term_qual #(.SEL_W(SEL_W)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .src_vec    (src_vec),
    .sel        (cfg_term_sel),
    .inv        (cfg_term_inv),
    .sw_gate_en (route == SW_TERMQ),
    .sw_bit     (cfg_sw_bit),
    .term       (term)
  );

  pfa_accept_core u_core (
    .clk     (clk),
    .rst     (rst),
    .in_eff  (in_eff),
    .mode    (mode),
    .rst_dom (cfg_rst_dom),
    .term    (term),
    .r_next  (r_next),
    .r_q     (local_acc)
  );

  pfa_bypass_mux #(.NGEN(NGEN), .SEL_W(SEL_W)) u_byp (
    .nbr_acc    (nbr_acc),
    .sel        (cfg_byp_sel),
    .en         (cfg_byp_en),
    .local_next (r_next),
    .idx        (byp_idx),
    .out_next   (out_next)
  );

  always_ff @(posedge clk) begin
    if (rst) accepted <= 1'b0;
    else     accepted <= out_next;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !accepted && !local_acc);

  // R10
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(cfg_byp_en) |-> accepted == $past(nbr_acc[byp_idx]));

  // R12
  local_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(cfg_byp_en) |-> accepted == local_acc);

endmodule

// File: tb/pwm_fault_accept_test.sv
`timescale 1ns/1ps
module pwm_fault_accept_test;

  localparam int NGEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fault_in = 0, duty_act = 0, blank_act = 0, gen_trig = 0;
  logic pci_src1 = 0, pci_src8 = 0, pci_src9 = 0;
  logic [NGEN-1:0] nbr_acc = '0;
  logic [2:0] cfg_mode = 0;
  logic cfg_rst_dom = 0;
  logic [2:0] cfg_term_sel = 0;
  logic cfg_term_inv = 0, cfg_sw_bit = 0;
  logic [1:0] cfg_sw_route = 0;
  logic cfg_byp_en = 0;
  logic [2:0] cfg_byp_sel = 0;
  logic local_acc, accepted;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_fault_accept #(.NGEN(NGEN)) uut (
    .clk(clk), .rst(rst), .fault_in(fault_in), .duty_act(duty_act),
    .blank_act(blank_act), .gen_trig(gen_trig), .pci_src1(pci_src1),
    .pci_src8(pci_src8), .pci_src9(pci_src9), .nbr_acc(nbr_acc),
    .cfg_mode(cfg_mode), .cfg_rst_dom(cfg_rst_dom), .cfg_term_sel(cfg_term_sel),
    .cfg_term_inv(cfg_term_inv), .cfg_sw_bit(cfg_sw_bit), .cfg_sw_route(cfg_sw_route),
    .cfg_byp_en(cfg_byp_en), .cfg_byp_sel(cfg_byp_sel),
    .local_acc(local_acc), .accepted(accepted)
  );

  // cycle model written from the requirements
  logic m_s = 0, m_e = 0, m_r = 0, m_acc = 0;
  always @(posedge clk) begin
    logic eff, rise, anye, setv, q, t, nxt;
    int md, idx;
    if (rst) begin
      m_s <= 0; m_e <= 0; m_r <= 0; m_acc <= 0;
    end else begin
      eff = (m_s | (((cfg_sw_route == 0) || (cfg_sw_route == 3)) && cfg_sw_bit))
          & ((cfg_sw_route != 1) || cfg_sw_bit);
      rise = eff && !m_e;
      anye = eff != m_e;
      md = (cfg_mode > 5) ? 0 : int'(cfg_mode);
      setv = (md == 1 || md == 4) ? rise : (md == 2 || md == 5) ? anye : eff;
      case (cfg_term_sel)
        3'd1: q = duty_act;  3'd2: q = blank_act; 3'd3: q = gen_trig;
        3'd4: q = pci_src1;  3'd5: q = pci_src8;  3'd6: q = pci_src9;
        default: q = 1'b1;
      endcase
      if (cfg_sw_route == 2) q = q & cfg_sw_bit;
      t = q ^ cfg_term_inv;
      if (md < 3) nxt = setv;
      else if (cfg_rst_dom) nxt = t ? 1'b0 : (setv ? 1'b1 : m_r);
      else nxt = setv ? 1'b1 : (t ? 1'b0 : m_r);
      case (cfg_byp_sel)
        3'd1: idx = 1; 3'd2: idx = 2; 3'd3: idx = 3; 3'd5: idx = 5; 3'd7: idx = 7;
        default: idx = 0;
      endcase
      m_s <= fault_in; m_e <= eff; m_r <= nxt;
      m_acc <= cfg_byp_en ? nbr_acc[idx] : nxt;
    end
  end

  function automatic string tag();
    if (cfg_byp_en) return "R10";
    if (cfg_mode > 5) return "R11";
    if (cfg_sw_route != 0) return "R9";
    if (cfg_mode < 3) return (cfg_mode == 0) ? "R3" : "R4";
    if (cfg_term_inv) return "R8";
    if (cfg_term_sel != 0) return "R7";
    return cfg_rst_dom ? "R6" : "R5";
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b mode=%0d tsel=%0d inv=%0b dom=%0b rt=%0d byp=%0b/%0d",
               req, act, exp, cfg_mode, cfg_term_sel, cfg_term_inv, cfg_rst_dom,
               cfg_sw_route, cfg_byp_en, cfg_byp_sel);
    end
  endtask

  task automatic run_random(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) fault_in = ~fault_in;
      duty_act = 1'($urandom); blank_act = 1'($urandom); gen_trig = 1'($urandom);
      pci_src1 = 1'($urandom); pci_src8 = 1'($urandom); pci_src9 = 1'($urandom);
      cfg_sw_bit = ($urandom_range(0, 3) == 0) ? ~cfg_sw_bit : cfg_sw_bit;
      nbr_acc = NGEN'($urandom);
      @(posedge clk);
      #5;
      chk(tag(), accepted, m_acc);
      chk(cfg_byp_en ? "R12" : tag(), local_acc, m_r);
    end
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fault_in = 1;
    repeat (3) @(posedge clk);
    #5;
    chk("R1", accepted, 1'b0);
    chk("R1", local_acc, 1'b0);
    @(negedge clk);
    fault_in = 0; rst = 0;
    repeat (3) @(posedge clk);
    // R2 latency: level mode, raise input before an edge
    @(negedge clk);
    fault_in = 1;
    @(posedge clk); #5;
    chk("R2", accepted, 1'b0);
    @(posedge clk); #5;
    chk("R2", accepted, 1'b1);
    chk("R3", local_acc, 1'b1);
    @(negedge clk);
    fault_in = 0;

    for (int md = 0; md < 8; md++)
      for (int ts = 0; ts < 8; ts++)
        for (int iv = 0; iv < 2; iv++)
          for (int dm = 0; dm < 2; dm++)
            for (int rt = 0; rt < 4; rt++) begin
              @(negedge clk);
              cfg_mode = 3'(md); cfg_term_sel = 3'(ts); cfg_term_inv = 1'(iv);
              cfg_rst_dom = 1'(dm); cfg_sw_route = 2'(rt);
              run_random(16);
            end

    @(negedge clk);
    cfg_mode = 3; cfg_sw_route = 0; cfg_sw_bit = 0;
    for (int en = 0; en < 2; en++)
      for (int bs = 0; bs < 8; bs++) begin
        @(negedge clk);
        cfg_byp_en = 1'(en); cfg_byp_sel = 3'(bs);
        run_random(24);
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule